// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable behavioural model of a small synchronous SRAM. It holds 256 words of 36 bits, and each word is split into four 9-bit bytes. A command is made of an address, a read/write select and per-byte write enables, and it is registered on a rising clock edge. The data for that command moves on the data bus exactly two rising edges later, for both reads and writes. Because the latency is the same in both directions, a host can interleave reads and writes on consecutive cycles and never needs an idle cycle to turn the bus around.

The data bus is split into a data input, a data output and a drive-enable output, which stands for the tri-state control of a shared bus. Three chip selects decide whether a load cycle starts an access. A built-in 4-beat burst sequencer produces the following addresses in linear or interleaved order. A clock-enable style hold input stalls the whole pipeline. An asynchronous output-enable input can silence the bus at any time.

Top module: `zt_sram`

## Requirements
- R1: A read command loaded on rising edge N places the addressed word on `dout` with `dout_en` high after edge N+2.
- R2: A write command loaded on edge N samples `din` at edge N+2. At that edge it writes byte i (bits 9i+8..9i) only where `ben_n[i]` is 0 on the command cycle. The other bytes keep their old value, and `ben_n` has no effect on a read command.
- R3: A load cycle (`adv`=0) starts an access only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. Any other combination is a deselect, which writes nothing.
- R4: After a deselect or a write command on edge N, `dout_en` is low after edge N+2. A read already in flight when a deselect arrives still delivers its data.
- R5: With `adv`=1, `addr` and the chip selects are ignored, and the next beat of the current burst is issued with the read/write choice of its load. The two low address bits follow (base+k) mod 4 when `burst_lin`=1 and base XOR k when `burst_lin`=0, for beat k = 1, 2, 3, 4 (k=4 wraps to the base). The upper address bits stay the same.
- R6: `adv`=1 while no burst is open (after reset or after a deselect) issues no access.
- R7: While `hold`=1, a clock edge changes nothing: no command is captured, no array write happens, and `dout`/`dout_en` keep their values.
- R8: `oe_n`=1 forces `dout_en` low at once, without a clock edge, and leaves the pipeline running.
- R9: Synchronous reset empties the pipeline, so `dout_en` is low after reset.
- R10: Reads and writes may alternate on consecutive cycles. A read issued two cycles after a write to the same address returns the newly written bytes.
- R11: In a burst write, the byte enables are sampled again on every beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | 1 freezes every register for that edge |
| sel_a_n | input | 1 | Active-low chip select |
| sel_b_n | input | 1 | Active-low chip select |
| sel_c | input | 1 | Active-high chip select |
| adv | input | 1 | 0 loads a new address, 1 advances the burst |
| rd | input | 1 | 1 read, 0 write (load cycles only) |
| addr | input | 8 | Word address |
| ben_n | input | 4 | Active-low byte write enables |
| burst_lin | input | 1 | 1 linear, 0 interleaved burst order (static) |
| oe_n | input | 1 | Asynchronous active-low output enable |
| din | input | 36 | Write data, sampled two edges after the command |
| dout | output | 36 | Registered read data |
| dout_en | output | 1 | Data output drive enable |

## Verification
Single write-then-read pairs establish the two-edge latency in each direction. Strictly alternating read/write streams then show that no idle cycle is needed and that the bus releases in the data-phase slot of each write. Partial byte masks, including a read that carries an all-enabled mask, separate correct byte merging from whole-word or read-side writes. Bursts that start mid-group in both orders, with a fifth beat, tell linear from interleaved sequencing and show the wrap. Deselect variants on each select pin, hold cycles with a write pending, and output-enable toggling separate real stalls from dropped or late data.

// File: rtl/zt_pkg.sv
package zt_pkg;

    localparam int ADDR_W  = 8;
    localparam int NBYTE   = 4;
    localparam int BYTE_W  = 9;
    localparam int DATA_W  = NBYTE * BYTE_W;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int BURST_W = 2;

    typedef struct packed {
        logic                valid;
        logic                rd;
        logic [ADDR_W-1:0]   addr;
        logic [NBYTE-1:0]    ben_n;
    } zt_cmd_t;

    // Offset of beat k inside a 4-word group starting at base.
    function automatic logic [BURST_W-1:0] burst_off(
        input logic [BURST_W-1:0] base,
        input logic [BURST_W-1:0] k,
        input logic               lin
    );
        logic [BURST_W-1:0] sum;
        sum = base + k;
        return lin ? sum : (base ^ k);
    endfunction

endpackage

// File: rtl/zt_issue.sv
module zt_issue
    import zt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              sel_ok,
    input  logic              adv,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NBYTE-1:0]  ben_n,
    input  logic              burst_lin,
    output zt_cmd_t           cmd_q
);

    logic               act_q,  act_d;
    logic               rd_q,   rd_d;
    logic [ADDR_W-1:0]  base_q, base_d;
    logic [BURST_W-1:0] cnt_q,  cnt_d;
    zt_cmd_t            cmd_d;

    always_comb begin
        act_d  = act_q;
        rd_d   = rd_q;
        base_d = base_q;
        cnt_d  = cnt_q;
        cmd_d  = '0;
        if (!adv) begin
            if (sel_ok) begin
                act_d       = 1'b1;
                rd_d        = rd;
                base_d      = addr;
                cnt_d       = '0;
                cmd_d.valid = 1'b1;
                cmd_d.rd    = rd;
                cmd_d.addr  = addr;
                cmd_d.ben_n = rd ? '1 : ben_n;
            end else begin
                act_d = 1'b0;
            end
        end else if (act_q) begin
            cnt_d       = cnt_q + 2'd1;
            cmd_d.valid = 1'b1;
            cmd_d.rd    = rd_q;
            cmd_d.addr  = {base_q[ADDR_W-1:BURST_W],
                           burst_off(base_q[BURST_W-1:0], cnt_q + 2'd1, burst_lin)};
            cmd_d.ben_n = rd_q ? '1 : ben_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            rd_q   <= 1'b1;
            base_q <= '0;
            cnt_q  <= '0;
            cmd_q  <= '0;
        end else if (!hold) begin
            act_q  <= act_d;
            rd_q   <= rd_d;
            base_q <= base_d;
            cnt_q  <= cnt_d;
            cmd_q  <= cmd_d;
        end
    end

    AST_DESEL_NOOP: assert property (@(posedge clk) disable iff (rst)
        (!hold && !adv && !sel_ok) |=> !cmd_q.valid);                       // R3
    AST_ADV_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!hold && adv && !act_q) |=> !cmd_q.valid);                          // R6
    AST_BURST_PAGE: assert property (@(posedge clk) disable iff (rst)
        (!hold && adv && act_q) |=> (cmd_q.valid && cmd_q.rd == $past(rd_q)
            && cmd_q.addr[ADDR_W-1:BURST_W] == $past(base_q[ADDR_W-1:BURST_W]))); // R5

endmodule

// File: rtl/zt_array.sv
module zt_array
    import zt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NBYTE-1:0]  ben_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < NBYTE; b++) begin
                if (!ben_n[b]) mem[addr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end
    end

    assign rdata = mem[addr];

    AST_BYTE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (we && !ben_n[0]) |=> mem[$past(addr)][BYTE_W-1:0] == $past(wdata[BYTE_W-1:0])); // R2

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic              sel_c,
    input  logic              adv,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NBYTE-1:0]  ben_n,
    input  logic              burst_lin,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    zt_cmd_t           s1_q;
    zt_cmd_t           s2_q;
    logic              sel_ok;
    logic              arr_we;
    logic [DATA_W-1:0] arr_rdata;
    logic [DATA_W-1:0] dout_q;
    logic              drv_q;

    assign sel_ok = ~sel_a_n & ~sel_b_n & sel_c;

    zt_issue u_issue (
        .clk       (clk),
        .rst       (rst),
        .hold      (hold),
        .sel_ok    (sel_ok),
        .adv       (adv),
        .rd        (rd),
        .addr      (addr),
        .ben_n     (ben_n),
        .burst_lin (burst_lin),
        .cmd_q     (s1_q)
    );

    always_ff @(posedge clk) begin
        if (rst)        s2_q <= '0;
        else if (!hold) s2_q <= s1_q;
    end

    // Array access is aligned to the data phase of the command.
    assign arr_we = !hold && s2_q.valid && !s2_q.rd;

    zt_array u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (arr_we),
        .addr  (s2_q.addr),
        .ben_n (s2_q.ben_n),
        .wdata (din),
        .rdata (arr_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q  <= 1'b0;
            dout_q <= '0;
        end else if (!hold) begin
            drv_q <= s2_q.valid && s2_q.rd;
            if (s2_q.valid && s2_q.rd) dout_q <= arr_rdata;
        end
    end

    assign dout    = dout_q;
    assign dout_en = drv_q & ~oe_n;

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (!hold && s2_q.valid && s2_q.rd) |=> drv_q);                         // R1
    AST_WRITE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (!hold && !(s2_q.valid && s2_q.rd)) |=> !drv_q);                     // R4
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(dout_q) && $stable(drv_q) && $stable(s2_q)));      // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!drv_q && !s2_q.valid && !s1_q.valid));                     // R9

endmodule

// File: tb/zt_sram_tb.sv
module zt_sram_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hold = 1'b0;
    logic        sel_a_n = 1'b1, sel_b_n = 1'b0, sel_c = 1'b1;
    logic        adv = 1'b0, rd = 1'b1;
    logic [7:0]  addr = '0;
    logic [3:0]  ben_n = 4'hF;
    logic        burst_lin = 1'b1;
    logic        oe_n = 1'b0;
    logic [35:0] din = '0;
    logic [35:0] dout;
    logic        dout_en;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    localparam logic [35:0] VA = 36'h123456789;
    localparam logic [35:0] VB = 36'hABCDEF012;
    localparam logic [35:0] VC = 36'h5A5A0F0F3;
    localparam logic [35:0] VZ = 36'hFFFFFFFFF;

    always #4 clk = ~clk;

    zt_sram dut_i (
        .clk(clk), .rst(rst), .hold(hold), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
        .sel_c(sel_c), .adv(adv), .rd(rd), .addr(addr), .ben_n(ben_n),
        .burst_lin(burst_lin), .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw,
                                          input logic [3:0] bn);
        logic [35:0] r = old;
        for (int b = 0; b < 4; b++) if (!bn[b]) r[b*9 +: 9] = nw[b*9 +: 9];
        return r;
    endfunction

    function automatic logic [35:0] pat(input logic [7:0] a);
        return {28'h3C3C3C3, a};
    endfunction

    task automatic chk(input string req, input logic exp_en, input logic [35:0] exp_d,
                       input logic use_d);
        tests++;
        if (dout_en !== exp_en || (use_d && dout !== exp_d)) begin
            fails++;
            $display("FAIL %s: actual en=%0b dout=%h, expected en=%0b dout=%h",
                     req, dout_en, dout, exp_en, exp_d);
        end
    endtask

    task automatic cyc(input logic a_n, input logic b_n, input logic c, input logic a,
                       input logic r, input logic [7:0] ad, input logic [3:0] bn,
                       input logic [35:0] d);
        sel_a_n = a_n; sel_b_n = b_n; sel_c = c; adv = a; rd = r;
        addr = ad; ben_n = bn; din = d;
        @(negedge clk);
    endtask

    task automatic rdc(input logic [7:0] ad, input logic [3:0] bn, input logic [35:0] d);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, ad, bn, d);
    endtask
    task automatic wrc(input logic [7:0] ad, input logic [3:0] bn, input logic [35:0] d);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, ad, bn, d);
    endtask
    task automatic dsc(input logic [35:0] d);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 4'hF, d);
    endtask
    task automatic advc(input logic [3:0] bn, input logic [35:0] d);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hFF, bn, d);
    endtask

    task automatic t_reset;
        chk("R9 reset bus idle", 1'b0, '0, 1'b0);
        advc(4'h0, VZ); advc(4'h0, VZ); advc(4'h0, VZ);
        chk("R6 advance without burst", 1'b0, '0, 1'b0);
    endtask

    task automatic t_write_read;
        wrc(8'd5, 4'h0, '0);
        dsc('0);
        rdc(8'd5, 4'hF, VA);
        chk("R4 write data phase releases bus", 1'b0, '0, 1'b0);
        dsc('0);
        dsc('0);
        chk("R1 R10 read two cycles after write", 1'b1, VA, 1'b1);
    endtask

    task automatic t_alternate;
        wrc(8'd10, 4'h0, '0);
        rdc(8'd5, 4'hF, '0);
        wrc(8'd11, 4'h0, VB);
        rdc(8'd10, 4'hF, '0);
        chk("R10 read between writes", 1'b1, VA, 1'b1);
        dsc(VC);
        chk("R4 write slot undriven", 1'b0, '0, 1'b0);
        dsc('0);
        chk("R10 back-to-back read of fresh write", 1'b1, VB, 1'b1);
        rdc(8'd11, 4'hF, '0);
        chk("R4 deselect slot undriven", 1'b0, '0, 1'b0);
        dsc('0);
        dsc('0);
        chk("R10 second alternating write", 1'b1, VC, 1'b1);
    endtask

    task automatic t_bytes;
        wrc(8'd5, 4'b1010, '0);
        dsc('0);
        rdc(8'd5, 4'h0, VB);
        dsc('0);
        dsc('0);
        chk("R2 partial byte write", 1'b1, merge(VA, VB, 4'b1010), 1'b1);
        rdc(8'd5, 4'hF, '0);
        dsc('0);
        dsc('0);
        chk("R2 read byte enables ignored", 1'b1, merge(VA, VB, 4'b1010), 1'b1);
    endtask

    task automatic t_select;
        wrc(8'd20, 4'h0, '0);
        dsc('0);
        dsc(VC);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd20, 4'h0, VZ);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd20, 4'h0, VZ);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd20, 4'h0, VZ);
        dsc(VZ);
        dsc(VZ);
        rdc(8'd20, 4'hF, '0);
        dsc('0);
        dsc('0);
        chk("R3 deselected writes ignored / R4 pending read completes", 1'b1, VC, 1'b1);
        dsc('0);
        chk("R4 bus off two edges after deselect", 1'b0, '0, 1'b0);
    endtask

    task automatic t_burst_read;
        for (int a = 32; a < 36; a++) begin
            wrc(8'(a), 4'h0, (a >= 34) ? pat(8'(a - 2)) : '0);
        end
        dsc(pat(8'd34));
        dsc(pat(8'd35));
        burst_lin = 1'b1;
        rdc(8'd34, 4'hF, '0);
        advc(4'h0, '0);
        advc(4'h0, '0);
        chk("R5 linear beat0", 1'b1, pat(8'd34), 1'b1);
        advc(4'h0, '0);
        chk("R5 linear beat1", 1'b1, pat(8'd35), 1'b1);
        advc(4'h0, '0);
        chk("R5 linear beat2 wraps", 1'b1, pat(8'd32), 1'b1);
        dsc('0);
        chk("R5 linear beat3", 1'b1, pat(8'd33), 1'b1);
        dsc('0);
        chk("R5 linear beat4 back to base", 1'b1, pat(8'd34), 1'b1);
        burst_lin = 1'b0;
        rdc(8'd33, 4'hF, '0);
        advc(4'h0, '0);
        advc(4'h0, '0);
        chk("R5 interleaved beat0", 1'b1, pat(8'd33), 1'b1);
        advc(4'h0, '0);
        chk("R5 interleaved beat1", 1'b1, pat(8'd32), 1'b1);
        dsc('0);
        chk("R5 interleaved beat2", 1'b1, pat(8'd35), 1'b1);
        dsc('0);
        chk("R5 interleaved beat3", 1'b1, pat(8'd34), 1'b1);
        burst_lin = 1'b1;
    endtask

    task automatic t_burst_write;
        wrc(8'd40, 4'h0, '0);
        advc(4'h0, '0);
        advc(4'h0, pat(8'd40));
        advc(4'h0, pat(8'd41));
        dsc(pat(8'd42));
        dsc(pat(8'd43));
        wrc(8'd40, 4'hF, '0);
        advc(4'b1110, '0);
        dsc(VZ);
        dsc(VB);
        rdc(8'd40, 4'hF, '0);
        rdc(8'd41, 4'hF, '0);
        rdc(8'd42, 4'hF, '0);
        chk("R11 beat with no bytes enabled", 1'b1, pat(8'd40), 1'b1);
        dsc('0);
        chk("R11 beat with one byte enabled", 1'b1, merge(pat(8'd41), VB, 4'b1110), 1'b1);
        dsc('0);
        chk("R11 untouched burst word", 1'b1, pat(8'd42), 1'b1);
    endtask

    task automatic t_hold;
        logic [35:0] m;
        m = merge(VA, VB, 4'b1010);
        dsc('0);
        dsc('0);
        rdc(8'd5, 4'hF, '0);
        hold = 1'b1;
        wrc(8'd5, 4'h0, VZ);
        hold = 1'b0;
        chk("R7 hold stalls capture", 1'b0, '0, 1'b0);
        dsc('0);
        chk("R7 read delayed by hold", 1'b0, '0, 1'b0);
        dsc('0);
        chk("R7 read after stall", 1'b1, m, 1'b1);
        hold = 1'b1;
        dsc(VZ);
        hold = 1'b0;
        chk("R7 output frozen under hold", 1'b1, m, 1'b1);
        dsc('0);
        chk("R7 pipeline resumes", 1'b0, '0, 1'b0);
        rdc(8'd5, 4'hF, '0);
        dsc('0);
        dsc('0);
        chk("R7 held write not performed", 1'b1, m, 1'b1);
    endtask

    task automatic t_oe;
        oe_n = 1'b1;
        #1;
        chk("R8 output enable forces release", 1'b0, '0, 1'b0);
        oe_n = 1'b0;
        #1;
        chk("R8 output enable restores drive", 1'b1, merge(VA, VB, 4'b1010), 1'b1);
        oe_n = 1'b1;
        rdc(8'd20, 4'hF, '0);
        dsc('0);
        dsc('0);
        chk("R8 bus released while disabled", 1'b0, '0, 1'b0);
        oe_n = 1'b0;
        #1;
        chk("R8 pipeline ran while disabled", 1'b1, VC, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write_read();
        t_alternate();
        t_bytes();
        t_select();
        t_burst_read();
        t_burst_write();
        t_hold();
        t_oe();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R1 watchdog: actual timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule